// File: doc/BRIEF.md
# Single-Bit Alias Window Bridge

This bridge sits on a bus as a slave and answers a 32 MiB alias window. Every aligned 32-bit word in the window stands for one bit of a 1 MiB backing region. An alias access is turned into accesses on a simple master port toward the backing memory. A read fetches the byte, halfword or word that holds the bit and returns that bit alone. A write fetches the same unit, changes only the addressed bit, and stores the unit back. Software can therefore flip a single flag without running its own load, mask and store sequence.

The backing byte address is the `BASE` parameter OR'd with the window offset shifted right by five. The access size then rounds it down. Which bit inside the fetched unit is used depends on the access size. The bridge keeps its slave port busy from acceptance until the final response. No other alias access can then fall between the fetch and the store-back.

Top module: `bitband_bridge`

## Requirements
- R1: The backing address is `BASE | ((s_addr & 0x1FF_FFFF) >> 5)`, rounded down to the access size. Size codes are 0 = byte, 1 = halfword, 2 = word. Both the fetch and any store-back use this address.
- R2: Address bits 25 and above of `s_addr` have no effect on the backing address or on the bit selected.
- R3: A read responds with the selected bit in `s_rdata[0]` and zeros in `s_rdata[31:1]`.
- R4: The bit index inside the fetched unit is `(offset >> 2) & (8*size_bytes - 1)`. Index bits [4:3] select the byte and bits [2:0] select the bit. Lanes are little-endian: unit byte k travels on bus lane (rounded address[1:0] + k).
- R5: A write fetches the unit and then stores it back with the selected bit set when `s_wdata[0]` is 1, or cleared when it is 0. All other bits of the unit keep their values, and `s_wdata[31:1]` is ignored.
- R6: The store-back byte strobes are 0001, 0011 or 1111 for byte, halfword and word, shifted left by the rounded address[1:0].
- R7: If the fetch returns an error, the response carries `s_err` = 1 and no store-back is issued.
- R8: If the store-back returns an error, the response carries `s_err` = 1.
- R9: Size code 3 is rejected with `s_err` = 1 and no backing access at all.
- R10: `s_ready` stays low from the acceptance of an access until its single `s_rvalid` pulse. A master request holds steady until it is accepted.
- R11: A synchronous active-low reset leaves `s_ready` = 1, `m_valid` = 0 and `s_rvalid` = 0, even when the reset arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Alias access request |
| s_ready | output | 1 | Bridge idle, request accepted this cycle |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| s_addr | input | AW | Alias address |
| s_wdata | input | 32 | Write data, bit 0 used |
| s_rvalid | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Read result, selected bit in bit 0 |
| s_err | output | 1 | Error flag with the response |
| m_valid | output | 1 | Backing request |
| m_ready | input | 1 | Backing request accepted |
| m_write | output | 1 | Backing request is a store |
| m_addr | output | AW | Rounded backing byte address |
| m_size | output | 2 | Backing access size code |
| m_strb | output | 4 | Store byte strobes |
| m_wdata | output | 32 | Store data, little-endian lanes |
| m_done | input | 1 | Backing access completed |
| m_rdata | input | 32 | Fetched data, valid with m_done |
| m_err | input | 1 | Backing access failed, valid with m_done |

## Verification
The hardest cases to reach are the failure paths inside the read-modify-write. The fetch must fail on one address while other accesses keep working, or the store-back must fail after a good fetch. The bench memory model has an error address and a store-error switch. It counts the requests it accepts, so a missing store-back after a failed fetch shows up in that count. A reset in the middle of a sequence is reached by stalling the model's acceptance for many cycles and pulling reset while the request is still pending.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } bb_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    localparam int unsigned DW      = 32;
    localparam int unsigned SB_W    = DW / 8;
    localparam int unsigned BIT_W   = $clog2(DW);
    localparam int unsigned ALIAS_SH = 5;

endpackage

// File: rtl/bb_xlate.sv
module bb_xlate
    import bb_pkg::*;
#(
    parameter int unsigned   AW    = 32,
    parameter int unsigned   WIN_W = 25,
    parameter logic [AW-1:0] BASE  = 32'h2000_0000
) (
    input  logic [AW-1:0]    alias_addr,
    input  logic [1:0]       size,
    output logic [AW-1:0]    back_addr,
    output logic [BIT_W-1:0] bus_bit,
    output logic [SB_W-1:0]  strb
);
    logic [WIN_W-1:0] offset;
    logic [AW-1:0]    raw_addr;
    logic [BIT_W-1:0] bit_idx;

    assign offset   = alias_addr[WIN_W-1:0];
    assign raw_addr = BASE | AW'(offset[WIN_W-1:ALIAS_SH]);

    always_comb begin
        case (size)
            SZ_BYTE: begin
                back_addr = raw_addr;
                bit_idx   = {2'b00, offset[4:2]};
                strb      = 4'b0001 << raw_addr[1:0];
            end
            SZ_HALF: begin
                back_addr = {raw_addr[AW-1:1], 1'b0};
                bit_idx   = {1'b0, offset[5:2]};
                strb      = 4'b0011 << {raw_addr[1], 1'b0};
            end
            default: begin
                back_addr = {raw_addr[AW-1:2], 2'b00};
                bit_idx   = offset[6:2];
                strb      = 4'b1111;
            end
        endcase
    end

    assign bus_bit = {back_addr[1:0], 3'b000} + bit_idx;

endmodule

// File: rtl/bb_lanes.sv
module bb_lanes
    import bb_pkg::*;
(
    input  logic [DW-1:0]    fetched,
    input  logic [BIT_W-1:0] bus_bit,
    input  logic             new_bit,
    output logic             sel_bit,
    output logic [DW-1:0]    merged
);
    assign sel_bit = fetched[bus_bit];

    for (genvar i = 0; i < DW; i++) begin : g_merge
        assign merged[i] = (bus_bit == BIT_W'(i)) ? new_bit : fetched[i];
    end

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic          s_write,
    input  logic [1:0]    s_size,
    input  logic [AW-1:0] s_addr,
    input  logic          s_wbit,
    output logic          s_rvalid,
    output logic          s_rbit,
    output logic          s_err,
    output logic          m_valid,
    input  logic          m_ready,
    output logic          m_write,
    output logic [DW-1:0] m_wdata,
    input  logic          m_done,
    input  logic          m_err,
    input  logic          sel_bit,
    input  logic [DW-1:0] merged,
    output logic [AW-1:0] cur_addr,
    output logic [1:0]    cur_size,
    output logic          cur_wbit
);
    typedef struct packed {
        bb_state_e     state;
        logic          is_write;
        logic          wbit;
        logic [1:0]    size;
        logic [AW-1:0] alias_addr;
        logic [DW-1:0] data;
        logic          err;
        logic          rbit;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (s_valid) begin
                    d.is_write   = s_write;
                    d.wbit       = s_wbit;
                    d.size       = s_size;
                    d.alias_addr = s_addr;
                    d.err        = 1'b0;
                    d.rbit       = 1'b0;
                    if (s_size == SZ_BAD) begin
                        d.err   = 1'b1;
                        d.state = ST_RESP;
                    end else begin
                        d.state = ST_RD_REQ;
                    end
                end
            end
            ST_RD_REQ: begin
                if (m_ready) d.state = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (m_done) begin
                    if (m_err) begin
                        d.err   = 1'b1;
                        d.state = ST_RESP;
                    end else begin
                        d.data = merged;
                        if (q.is_write) begin
                            d.state = ST_WR_REQ;
                        end else begin
                            d.rbit  = sel_bit;
                            d.state = ST_RESP;
                        end
                    end
                end
            end
            ST_WR_REQ: begin
                if (m_ready) d.state = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (m_done) begin
                    d.err   = m_err;
                    d.state = ST_RESP;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, size: SZ_BYTE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign s_ready  = (q.state == ST_IDLE);
    assign s_rvalid = (q.state == ST_RESP);
    assign s_rbit   = q.rbit;
    assign s_err    = q.err;
    assign m_valid  = (q.state == ST_RD_REQ) || (q.state == ST_WR_REQ);
    assign m_write  = (q.state == ST_WR_REQ);
    assign m_wdata  = q.data;
    assign cur_addr = q.alias_addr;
    assign cur_size = q.size;
    assign cur_wbit = q.wbit;

    // R10: once accepted, the slave side stays busy
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready |=> !s_ready);

    // R10: a pending master request holds until taken
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_write));

    // R10: idle, request and response phases never overlap
    a_r10_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_ready, m_valid, s_rvalid}));

    // R7: a failed fetch goes straight to an error response
    a_r7_fetch_err_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD_WAIT) && m_done && m_err |=> s_rvalid && s_err && !m_valid);

    // R9: illegal size is answered at once with an error
    a_r9_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready && (s_size == SZ_BAD) |=> s_rvalid && s_err);

    // R5: a store-back only starts right after a completed fetch
    a_r5_store_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) && m_write |-> $past(m_done) && !$past(m_err));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int unsigned   AW    = 32,
    parameter int unsigned   WIN_W = 25,
    parameter logic [AW-1:0] BASE  = 32'h2000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic          s_write,
    input  logic [1:0]    s_size,
    input  logic [AW-1:0] s_addr,
    input  logic [31:0]   s_wdata,
    output logic          s_rvalid,
    output logic [31:0]   s_rdata,
    output logic          s_err,
    output logic          m_valid,
    input  logic          m_ready,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [1:0]    m_size,
    output logic [3:0]    m_strb,
    output logic [31:0]   m_wdata,
    input  logic          m_done,
    input  logic [31:0]   m_rdata,
    input  logic          m_err
);
    localparam int unsigned REGION_W = WIN_W - ALIAS_SH;

    logic [AW-1:0]    cur_addr;
    logic [1:0]       cur_size;
    logic             cur_wbit;
    logic [BIT_W-1:0] bus_bit;
    logic             sel_bit;
    logic [DW-1:0]    merged;
    logic             rbit;
    logic [SB_W-1:0]  strb;

    bb_xlate #(.AW(AW), .WIN_W(WIN_W), .BASE(BASE)) u_xlate (
        .alias_addr (cur_addr),
        .size       (cur_size),
        .back_addr  (m_addr),
        .bus_bit    (bus_bit),
        .strb       (strb)
    );

    bb_lanes u_lanes (
        .fetched (m_rdata),
        .bus_bit (bus_bit),
        .new_bit (cur_wbit),
        .sel_bit (sel_bit),
        .merged  (merged)
    );

    bb_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .s_write  (s_write),
        .s_size   (s_size),
        .s_addr   (s_addr),
        .s_wbit   (s_wdata[0]),
        .s_rvalid (s_rvalid),
        .s_rbit   (rbit),
        .s_err    (s_err),
        .m_valid  (m_valid),
        .m_ready  (m_ready),
        .m_write  (m_write),
        .m_wdata  (m_wdata),
        .m_done   (m_done),
        .m_err    (m_err),
        .sel_bit  (sel_bit),
        .merged   (merged),
        .cur_addr (cur_addr),
        .cur_size (cur_size),
        .cur_wbit (cur_wbit)
    );

    assign m_size  = cur_size;
    assign m_strb  = m_write ? strb : '0;
    assign s_rdata = {31'b0, rbit};

    // R1: every backing request stays inside the region named by BASE
    a_r1_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_addr >> REGION_W) == (BASE >> REGION_W));

    // R6: a store-back always enables at least one byte lane
    a_r6_strb_set: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_write |-> m_strb != 4'b0000);

endmodule

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;
    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_write = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready, s_rvalid, s_err;
    logic [31:0] s_rdata;
    logic        m_valid, m_write;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic [3:0]  m_strb;
    logic        m_ready = 1'b0, m_done = 1'b0, m_err = 1'b0;
    logic [31:0] m_rdata = '0;

    always #2 clk = ~clk;

    bitband_bridge #(.BASE(BASE)) u0 (.*);

    // backing memory model
    logic [7:0]  mem [8];
    int          stall = 0;
    logic        err_rd_en = 1'b0, err_wr_en = 1'b0;
    logic [31:0] err_rd_addr = '0;
    logic        pend = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wd = '0;
    logic [3:0]  p_strb = '0;
    int          cnt = 0, n_rd = 0, n_wr = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
    logic [3:0]  last_wr_strb = '0;

    always @(posedge clk) begin
        m_ready <= 1'b0;
        m_done  <= 1'b0;
        m_err   <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= 0;
            mem[0] <= 8'h81; mem[1] <= 8'h42; mem[2] <= 8'h00; mem[3] <= 8'hFF;
            mem[4] <= 8'h10; mem[5] <= 8'h5A; mem[6] <= 8'h3C; mem[7] <= 8'h01;
        end else if (pend) begin
            pend   <= 1'b0;
            m_done <= 1'b1;
            if (p_we) begin
                if (err_wr_en) m_err <= 1'b1;
                else for (int l = 0; l < 4; l++)
                    if (p_strb[l]) mem[{p_addr[2], 2'(l)}] <= p_wd[8*l +: 8];
            end else begin
                if (err_rd_en && p_addr == err_rd_addr) m_err <= 1'b1;
                for (int l = 0; l < 4; l++) m_rdata[8*l +: 8] <= mem[{p_addr[2], 2'(l)}];
            end
        end else if (m_valid && m_ready) begin
            pend   <= 1'b1;
            p_we   <= m_write;
            p_addr <= m_addr;
            p_wd   <= m_wdata;
            p_strb <= m_strb;
            if (m_write) begin
                n_wr <= n_wr + 1;
                last_wr_addr <= m_addr;
                last_wr_strb <= m_strb;
                last_wr_data <= m_wdata;
            end else begin
                n_rd <= n_rd + 1;
                last_rd_addr <= m_addr;
            end
        end else if (m_valid) begin
            if (cnt >= stall) begin
                m_ready <= 1'b1;
                cnt     <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        int guard = 0;
        bit busy_ok = 1'b1;
        @(negedge clk);
        s_valid = 1'b1; s_write = we; s_size = sz; s_addr = a; s_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        while (!s_rvalid && guard < 1000) begin
            if (s_ready) busy_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        rd = s_rdata;
        er = s_err;
        check(busy_ok && s_rvalid, "R10 busy until single response", {31'b0, busy_ok}, 32'd1);
    endtask

    // read vector table: size, alias address, expected backing offset, expected bit
    localparam int NV = 12;
    localparam logic [1:0]  V_SZ  [NV] = '{0, 0, 0, 0, 1, 1, 2, 2, 2, 0, 2, 0};
    localparam logic [31:0] V_AD  [NV] = '{32'h2200_0000, 32'h2200_001C, 32'h2200_0024,
                                           32'h2200_0028, 32'h2200_0060, 32'h2200_0040,
                                           32'h2200_00A0, 32'h2200_00A4, 32'h2200_00E0,
                                           32'h2A00_0024, 32'h2200_007C, 32'h2200_0090};
    localparam logic [31:0] V_OFF [NV] = '{0, 0, 1, 1, 2, 2, 4, 4, 4, 1, 0, 4};
    localparam logic        V_BIT [NV] = '{1, 1, 1, 0, 1, 0, 0, 1, 1, 1, 1, 1};

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        int rd0, wr0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(s_ready && !m_valid && !s_rvalid, "R11 reset outputs",
              {29'b0, s_ready, m_valid, s_rvalid}, 32'h4);
        rst_n = 1'b1;

        // R1 R2 R3 R4 read table
        for (int i = 0; i < NV; i++) begin
            stall = i % 3;
            access(1'b0, V_SZ[i], V_AD[i], 32'h0, rd, er);
            check(rd == {31'b0, V_BIT[i]} && !er, "R3 R4 read bit", rd, {31'b0, V_BIT[i]});
            check(last_rd_addr == BASE + V_OFF[i], (i == 9) ? "R2 high bits ignored" : "R1 backing address",
                  last_rd_addr, BASE + V_OFF[i]);
        end
        stall = 1;

        // R5 R6 halfword clear of byte3 bit0
        access(1'b1, 2'd1, 32'h2200_0060, 32'h0, rd, er);
        check(!er && mem[3] == 8'hFE && mem[2] == 8'h00, "R5 half clear", {mem[3], mem[2]}, 16'hFE00);
        check(last_wr_strb == 4'b1100, "R6 half strobes", last_wr_strb, 4'b1100);
        check(last_wr_addr == BASE + 2, "R1 store-back address", last_wr_addr, BASE + 2);
        check(last_wr_data[31:16] == 16'hFE00, "R4 lane placement", last_wr_data[31:16], 16'hFE00);
        access(1'b0, 2'd1, 32'h2200_0060, 32'h0, rd, er);
        check(rd == 32'd0, "R5 read back cleared", rd, 32'd0);

        // R5 byte set, then data bits above bit 0 ignored
        access(1'b1, 2'd0, 32'h2200_0028, 32'h1, rd, er);
        check(mem[1] == 8'h46, "R5 byte set", mem[1], 8'h46);
        check(last_wr_strb == 4'b0010, "R6 byte strobes", last_wr_strb, 4'b0010);
        access(1'b1, 2'd0, 32'h2200_0024, 32'hFFFF_FFFE, rd, er);
        check(mem[1] == 8'h44, "R5 upper wdata ignored", mem[1], 8'h44);

        // R5 R6 word set of byte7 bit1
        access(1'b1, 2'd2, 32'h2200_00E4, 32'h1, rd, er);
        check(mem[7] == 8'h03 && mem[4] == 8'h10 && mem[5] == 8'h5A && mem[6] == 8'h3C,
              "R5 word set others kept", {mem[7], mem[6], mem[5], mem[4]}, 32'h033C5A10);
        check(last_wr_strb == 4'b1111 && last_wr_addr == BASE + 4, "R6 word strobes",
              {last_wr_strb, last_wr_addr[27:0]}, {4'hF, 28'h0000004});

        // R7 fetch error: error reply, no store-back
        err_rd_en = 1'b1; err_rd_addr = BASE + 4;
        rd0 = n_rd; wr0 = n_wr;
        access(1'b1, 2'd0, 32'h2200_0090, 32'h0, rd, er);
        check(er == 1'b1, "R7 fetch error reported", {31'b0, er}, 32'd1);
        check(n_wr == wr0 && n_rd == rd0 + 1, "R7 no store-back", n_wr - wr0, 32'd0);
        check(mem[4] == 8'h10, "R7 memory untouched", mem[4], 8'h10);
        err_rd_en = 1'b0;

        // R8 store-back error
        err_wr_en = 1'b1;
        access(1'b1, 2'd0, 32'h2200_0000, 32'h0, rd, er);
        check(er == 1'b1, "R8 store error reported", {31'b0, er}, 32'd1);
        err_wr_en = 1'b0;

        // R9 illegal size
        rd0 = n_rd; wr0 = n_wr;
        access(1'b0, 2'd3, 32'h2200_0000, 32'h0, rd, er);
        check(er == 1'b1, "R9 size 3 rejected", {31'b0, er}, 32'd1);
        check(n_rd == rd0 && n_wr == wr0, "R9 no backing access", n_rd - rd0, 32'd0);

        // clean access after errors
        access(1'b0, 2'd0, 32'h2200_0000, 32'h0, rd, er);
        check(!er && rd == 32'd1, "R3 clean read after errors", {er, rd[30:0]}, 32'd1);

        // R11 reset during a stalled sequence
        stall = 50;
        @(negedge clk);
        s_valid = 1'b1; s_write = 1'b1; s_size = 2'd0; s_addr = 32'h2200_0000; s_wdata = 32'h0;
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(m_valid && !s_ready, "R10 stalled request pending", {30'b0, m_valid, s_ready}, 32'h2);
        rst_n = 1'b0;
        @(negedge clk);
        check(s_ready && !m_valid && !s_rvalid, "R11 mid-sequence reset",
              {29'b0, s_ready, m_valid, s_rvalid}, 32'h4);
        rst_n = 1'b1;
        stall = 0;
        access(1'b0, 2'd0, 32'h2200_001C, 32'h0, rd, er);
        check(rd == 32'd1 && !er, "R11 works after reset", rd, 32'd1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule